// File: doc/BRIEF.md
# Memory Chip-Select Decoder

This block turns the address and control lines of a small processor into chip selects and strobes for its memory devices. The processor has a 16-bit address bus, a read/write line (high for read, low for write) and an active-low memory request. The address space is cut into eight 8K banks. Banks 0 and 1 (0x0000 to 0x3FFF) are ROM. Bank 2 (0x4000 to 0x5FFF) is a reserved hole. Banks 3 to 7 (0x6000 to 0xFFFF) are RAM. A gated 3-to-8 decoder takes the three top address bits as its select inputs. Its enables are qualified by the memory request. It drives one active-low select per bank, and the hole output is masked so that it never asserts.

A strobe stage produces an active-low write enable for RAM and an active-low output enable for any device that is read. A debug flag marks requests that fall in the reserved window. The parameter `FULL_DECODE` picks the decoding scheme. When it is 1, every bank is uniquely addressed. When it is 0, the decoder uses linear selection: the middle select input is wired to A15 instead of A14, so A14 is not decoded and each reachable device answers at two aliased 8K windows.

The block has no clock and no state. Its outputs follow its inputs combinationally.

Top module: `memcs_decoder`

## Requirements
- R1: While `mreq_n` is 1, all eight `cs_n` bits, `we_n` and `oe_n` are 1 and `rsvd_hit` is 0.
- R2: In full mode with `mreq_n` at 0, `cs_n[k]` is 0 exactly when `addr[15:13]` equals k, for k in 0, 1 and 3 to 7. At most one `cs_n` bit is 0 at any time.
- R3: In full mode, an address from 0x4000 to 0x5FFF asserts no `cs_n` bit (all read 0xFF).
- R4: `we_n` is 0 only when `mreq_n` is 0, `rd_wr_n` is 0 and the RAM region is selected. A write to ROM leaves both `we_n` and `oe_n` at 1.
- R5: `oe_n` is 0 when `mreq_n` is 0, `rd_wr_n` is 1 and a ROM or RAM device is selected. A read of the hole leaves `oe_n` at 1.
- R6: In partial mode, the selected bank index is {A15, A15, A13}. For example, 0x4000 selects bank 0, 0x6000 selects bank 1, 0x8000 selects bank 6 and 0xA000 selects bank 7. In this mode, A15 at 0 is the ROM region and A15 at 1 is the RAM region.
- R7: `rsvd_hit` is 1 exactly when `mreq_n` is 0 and `addr` lies in 0x4000 to 0x5FFF. This holds in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 16 | Processor address bus |
| mreq_n | input | 1 | Memory request, active low |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| cs_n | output | 8 | Per-bank chip selects, active low, bit k = bank k |
| we_n | output | 1 | RAM write enable, active low |
| oe_n | output | 1 | Device output enable, active low |
| rsvd_hit | output | 1 | Debug flag: request falls in the reserved window |

## Verification
The bench targets the edges of each region:
- 0x3FFF against 0x4000, and 0x5FFF against 0x6000. An off-by-one threshold would either select a device inside the hole or leave the first RAM or last ROM word unselected.
- A write to ROM and a read of the hole. A strobe stage that ignores the region would pulse `we_n` into ROM, or drive `oe_n` with no device selected.
- A request held idle at reset. Ungated decoder enables would let chip selects assert while `mreq_n` is 1.

A full sweep of all 65536 addresses in both modes catches any bank mapped to the wrong select. In partial mode, the sweep also catches an alias folded onto the wrong bank, or a region taken from A14 where only A15 is decoded.

// File: rtl/memcs_pkg.sv
package memcs_pkg;

    typedef enum logic [1:0] {
        RGN_ROM  = 2'd0,
        RGN_HOLE = 2'd1,
        RGN_RAM  = 2'd2,
        RGN_IDLE = 2'd3
    } region_t;

endpackage

// File: rtl/memcs_region_classify.sv
module memcs_region_classify
    import memcs_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter bit          FULL_DECODE = 1'b1,
    parameter logic [15:0] HOLE_BASE   = 16'h4000,
    parameter logic [15:0] RAM_BASE    = 16'h6000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mreq_n,
    output region_t           region,
    output logic              rsvd_hit
);

    logic in_hole;

    assign in_hole  = (addr >= ADDR_W'(HOLE_BASE)) && (addr < ADDR_W'(RAM_BASE));
    assign rsvd_hit = !mreq_n && in_hole;

    generate
        if (FULL_DECODE) begin : g_full
            always_comb begin
                if (mreq_n)                         region = RGN_IDLE;
                else if (addr < ADDR_W'(HOLE_BASE)) region = RGN_ROM;
                else if (in_hole)                   region = RGN_HOLE;
                else                                region = RGN_RAM;
            end
        end else begin : g_partial
            always_comb begin
                if (mreq_n)              region = RGN_IDLE;
                else if (addr[ADDR_W-1]) region = RGN_RAM;
                else                     region = RGN_ROM;
            end
        end
    endgenerate

endmodule

// File: rtl/memcs_bank_decoder.sv
module memcs_bank_decoder #(
    parameter int SEL_W = 3,
    localparam int NOUT = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             en_hi,
    input  logic             en_lo_a_n,
    input  logic             en_lo_b_n,
    output logic [NOUT-1:0]  y_n
);

    logic enabled;

    assign enabled = en_hi && !en_lo_a_n && !en_lo_b_n;

    generate
        for (genvar i = 0; i < NOUT; i++) begin : g_out
            assign y_n[i] = !(enabled && (sel == SEL_W'(i)));
        end
    endgenerate

    always_comb begin
        assert_onehot_R2: assert ($onehot0(~y_n))
            else $error("decoder drives more than one output");
    end

endmodule

// File: rtl/memcs_strobe_gen.sv
module memcs_strobe_gen
    import memcs_pkg::*;
(
    input  logic    mreq_n,
    input  logic    rd_wr_n,
    input  region_t region,
    output logic    we_n,
    output logic    oe_n
);

    logic dev_sel;

    assign dev_sel = (region == RGN_ROM) || (region == RGN_RAM);

    always_comb begin
        we_n = 1'b1;
        oe_n = 1'b1;
        if (!mreq_n) begin
            unique case (region)
                RGN_RAM: begin
                    we_n = rd_wr_n;
                    oe_n = !rd_wr_n;
                end
                RGN_ROM: oe_n = !rd_wr_n;
                RGN_HOLE, RGN_IDLE: begin
                    we_n = 1'b1;
                    oe_n = 1'b1;
                end
                default: begin
                    we_n = 1'b1;
                    oe_n = 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        if (!oe_n) begin
            assert_oe_sel_R5: assert (dev_sel && rd_wr_n)
                else $error("output enable without a read of a device");
        end
    end

endmodule

// File: rtl/memcs_decoder.sv
module memcs_decoder
    import memcs_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int BANK_W      = 3,
    parameter int HOLE_BANK   = 2,
    parameter bit FULL_DECODE = 1'b1,
    localparam int NBANK      = 1 << BANK_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mreq_n,
    input  logic              rd_wr_n,
    output logic [NBANK-1:0]  cs_n,
    output logic              we_n,
    output logic              oe_n,
    output logic              rsvd_hit
);

    localparam logic [NBANK-1:0] HOLE_MASK = NBANK'(1) << HOLE_BANK;

    logic [BANK_W-1:0] top_bits;
    logic [BANK_W-1:0] bank_sel;
    logic [NBANK-1:0]  dec_y_n;
    region_t           region;

    assign top_bits = addr[ADDR_W-1 -: BANK_W];

    generate
        if (FULL_DECODE) begin : g_abs
            assign bank_sel = top_bits;
        end else begin : g_lin
            always_comb begin
                bank_sel           = top_bits;
                bank_sel[BANK_W-2] = top_bits[BANK_W-1];
            end
        end
    endgenerate

    memcs_bank_decoder #(.SEL_W(BANK_W)) u_dec (
        .sel       (bank_sel),
        .en_hi     (1'b1),
        .en_lo_a_n (mreq_n),
        .en_lo_b_n (1'b0),
        .y_n       (dec_y_n)
    );

    assign cs_n = dec_y_n | HOLE_MASK;

    memcs_region_classify #(
        .ADDR_W      (ADDR_W),
        .FULL_DECODE (FULL_DECODE)
    ) u_cls (
        .addr     (addr),
        .mreq_n   (mreq_n),
        .region   (region),
        .rsvd_hit (rsvd_hit)
    );

    memcs_strobe_gen u_stb (
        .mreq_n  (mreq_n),
        .rd_wr_n (rd_wr_n),
        .region  (region),
        .we_n    (we_n),
        .oe_n    (oe_n)
    );

    always_comb begin
        if (mreq_n) begin
            assert_idle_R1: assert ((&cs_n) && we_n && oe_n && !rsvd_hit)
                else $error("activity while memory request idle");
        end
        if (rsvd_hit && FULL_DECODE) begin
            assert_hole_quiet_R3: assert (&cs_n)
                else $error("select asserted in reserved window");
        end
        if (!we_n) begin
            assert_we_ram_R4: assert (!rd_wr_n && (&cs_n[1:0]) && !(&cs_n))
                else $error("write enable without a RAM select");
        end
        if (!oe_n) begin
            assert_oe_dev_R5: assert (!(&cs_n))
                else $error("output enable with no select");
        end
    end

endmodule

// File: tb/sim_memcs_decoder.sv
`timescale 1ns/1ps
module sim_memcs_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        mreq_n = 1'b1;
    logic        rd_wr_n = 1'b1;
    logic [7:0]  cs_n, cs1_n;
    logic        we_n, oe_n, rsv, we1_n, oe1_n, rsv1;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    memcs_decoder #(.FULL_DECODE(1'b1)) u0 (
        .addr(addr), .mreq_n(mreq_n), .rd_wr_n(rd_wr_n),
        .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .rsvd_hit(rsv)
    );

    memcs_decoder #(.FULL_DECODE(1'b0)) u1 (
        .addr(addr), .mreq_n(mreq_n), .rd_wr_n(rd_wr_n),
        .cs_n(cs1_n), .we_n(we1_n), .oe_n(oe1_n), .rsvd_hit(rsv1)
    );

    // {addr, mreq_n, rd_wr_n, cs_n, we_n, oe_n, rsvd_hit}
    localparam logic [28:0] VEC [16] = '{
        {16'h0000, 1'b0, 1'b1, 8'hFE, 1'b1, 1'b0, 1'b0},
        {16'h1FFF, 1'b0, 1'b1, 8'hFE, 1'b1, 1'b0, 1'b0},
        {16'h2000, 1'b0, 1'b1, 8'hFD, 1'b1, 1'b0, 1'b0},
        {16'h3FFF, 1'b0, 1'b0, 8'hFD, 1'b1, 1'b1, 1'b0},
        {16'h4000, 1'b0, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b1},
        {16'h5FFF, 1'b0, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b1},
        {16'h6000, 1'b0, 1'b0, 8'hF7, 1'b0, 1'b1, 1'b0},
        {16'h7FFF, 1'b0, 1'b1, 8'hF7, 1'b1, 1'b0, 1'b0},
        {16'h8000, 1'b0, 1'b0, 8'hEF, 1'b0, 1'b1, 1'b0},
        {16'hA000, 1'b0, 1'b1, 8'hDF, 1'b1, 1'b0, 1'b0},
        {16'hC000, 1'b0, 1'b0, 8'hBF, 1'b0, 1'b1, 1'b0},
        {16'hFFFF, 1'b0, 1'b1, 8'h7F, 1'b1, 1'b0, 1'b0},
        {16'hFFFF, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b0},
        {16'h4800, 1'b1, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b0},
        {16'hE123, 1'b0, 1'b0, 8'h7F, 1'b0, 1'b1, 1'b0},
        {16'h0123, 1'b0, 1'b0, 8'hFE, 1'b1, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%h act=%h exp=%h", req, addr, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] a, input logic m, input logic rw);
        @(posedge clk);
        addr    = a;
        mreq_n  = m;
        rd_wr_n = rw;
        @(negedge clk);
    endtask

    initial begin
        // reset state: request idle (R1)
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset cs", cs_n, 8'hFF);
        chk("R1 reset strobes", {6'd0, we_n, oe_n}, 8'h03);
        chk("R1 reset partial cs", cs1_n, 8'hFF);
        rst_n = 1'b1;

        // table walk, full mode (R2 R3 R4 R5 R7)
        for (int i = 0; i < 16; i++) begin
            apply(VEC[i][28:13], VEC[i][12], VEC[i][11]);
            chk("R2 R3 table cs", cs_n, VEC[i][10:3]);
            chk("R4 table we_n", {7'd0, we_n}, {7'd0, VEC[i][2]});
            chk("R5 table oe_n", {7'd0, oe_n}, {7'd0, VEC[i][1]});
            chk("R7 table rsvd", {7'd0, rsv}, {7'd0, VEC[i][0]});
        end

        // partial mode aliases (R6)
        apply(16'h4000, 1'b0, 1'b1);
        chk("R6 alias 4000", cs1_n, 8'hFE);
        chk("R7 partial rsvd", {7'd0, rsv1}, 8'h01);
        apply(16'h6000, 1'b0, 1'b0);
        chk("R6 alias 6000", cs1_n, 8'hFD);
        chk("R6 rom write strobes", {6'd0, we1_n, oe1_n}, 8'h03);
        apply(16'h8000, 1'b0, 1'b0);
        chk("R6 alias 8000", cs1_n, 8'hBF);
        chk("R6 ram write we", {7'd0, we1_n}, 8'h00);
        apply(16'hA000, 1'b0, 1'b1);
        chk("R6 alias A000", cs1_n, 8'h7F);

        // full sweep, both modes
        for (int a = 0; a < 65536; a++) begin
            logic [15:0] av;
            logic [2:0]  kf, kp;
            logic        rw, ramf, romf;
            logic [7:0]  ecf, ecp;
            av   = 16'(a);
            rw   = av[0];
            kf   = av[15:13];
            kp   = {av[15], av[15], av[13]};
            ramf = (kf >= 3'd3);
            romf = (kf <= 3'd1);
            ecf  = (kf == 3'd2) ? 8'hFF : ~(8'h01 << kf);
            ecp  = ~(8'h01 << kp);
            apply(av, 1'b0, rw);
            chk("R2 R3 sweep cs", cs_n, ecf);
            chk("R4 R5 sweep strobes", {6'd0, we_n, oe_n},
                {6'd0, !(!rw && ramf), !(rw && (ramf || romf))});
            chk("R7 sweep rsvd", {7'd0, rsv}, {7'd0, kf == 3'd2});
            chk("R6 sweep cs", cs1_n, ecp);
            chk("R6 sweep strobes", {6'd0, we1_n, oe1_n},
                {6'd0, !(!rw && av[15]), !rw});
        end

        // idle after activity (R1)
        apply(16'h6000, 1'b1, 1'b0);
        chk("R1 idle cs", cs_n, 8'hFF);
        chk("R1 idle strobes", {5'd0, we_n, oe_n, rsv}, 8'h06);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #600000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule